// File: doc/BRIEF.md
# Loop-free wavefront allocator

This block matches N requesters to N resources in one clock cycle. A flat request matrix comes in, one bit per requester/resource pair, and a grant matrix of the same shape goes out combinationally in the same cycle. Inside, the wavefront principle is used: two requests can only conflict when they share a row or a column, so every request on one wrapped diagonal can be decided at once. Diagonals are then taken one after another, and each grant removes its row and column from the later diagonals.

A tiled wavefront array normally closes its row and column token paths into rings, which leaves combinational loops that timing tools cannot handle. Here one unrolled, loop-free copy of the array is built for every possible starting diagonal. Each copy begins with all rows and columns free at its own start, and an AND-OR selector passes on the grants of the copy that matches a registered priority pointer. The pointer moves on by one diagonal after every enabled allocation, so the highest priority rotates and no request that is held waits forever.

Matrix bits are packed row-major: the pair (requester r, resource c) sits at bit r*N + c of both `req` and `gnt`.

Top module: `wfa_alloc`

## Requirements
- R1: A grant bit is only ever set where the matching request bit is set in the same cycle.
- R2: In every cycle each requester row and each resource column of `gnt` holds at most one set bit.
- R3: The grant matrix is maximal: every request left ungranted has its row or its column already granted to another pair.
- R4: The grants equal the result of visiting diagonals p, p+1, ... p+N-1 (mod N) in that order, where p is the priority pointer and pair (r,c) lies on diagonal (r+c) mod N; on each diagonal every requested pair whose row and column are both still free is granted.
- R5: While `rst_n` is low, and on the first allocation after it rises, the priority pointer is 0; with every request set, the grants are then exactly diagonal 0.
- R6: The priority pointer advances by one at each rising clock edge where `alloc_en` is high, and holds its value at edges where `alloc_en` is low.
- R7: From N-1 the pointer wraps to 0.
- R8: An all-zero request matrix yields an all-zero grant matrix.
- R9: A request held continuously is granted within at most N consecutive enabled allocations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pointer updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the priority pointer |
| alloc_en | input | 1 | High when this cycle's grants are used; advances the pointer |
| req | input | N*N | Request matrix, pair (r,c) at bit r*N+c |
| gnt | output | N*N | Grant matrix, same layout, combinational from `req` and the pointer |

## Verification
The only state is the priority pointer, and a wrong pointer value shows at the ports in the same cycle it is present. With every request bit set, the grant matrix is exactly the permutation on the active diagonal, so a stuck, skipped or mis-wrapped pointer changes `gnt` at the first sample after the faulty edge. A fault in one replicated copy or in the output selector shows only while that copy is active, which the rotating pointer reaches within N enabled cycles. Random matrices compared against an independent diagonal-walk model cover the tile and token-chain logic.

// File: rtl/wfa_pkg.sv
// Package wfa_pkg
// Shared helper functions for the wavefront allocator: index widths and
// diagonal arithmetic. Assumes sizes of at least 1.
package wfa_pkg;

    // Width of an index that counts 0..n-1, at least one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Column visited by row r at step k of a walk that starts at diagonal s.
    function automatic int unsigned col_at(input int unsigned s,
                                           input int unsigned k,
                                           input int unsigned r,
                                           input int unsigned n);
        return (s + k + n - r) % n;
    endfunction

endpackage

// File: rtl/wfa_tile.sv
// Module wfa_tile
// One cell of the wavefront array. Grants its request when both its row
// and its column are still free, and passes the updated free flags on.
// Assumes the flags arrive from the previous diagonal of the same copy.
module wfa_tile (
    input  logic req_i,
    input  logic row_free_i,
    input  logic col_free_i,
    output logic gnt_o,
    output logic row_free_o,
    output logic col_free_o
);

    // Grant and token update for this pair.
    always_comb begin
        gnt_o      = req_i & row_free_i & col_free_i;
        row_free_o = row_free_i & ~gnt_o;
        col_free_o = col_free_i & ~gnt_o;
    end

endmodule

// File: rtl/wfa_array.sv
// Module wfa_array
// One unrolled wavefront copy that always starts at diagonal START. The
// token chains of rows and columns begin at START with all lines free and
// run through N diagonals without closing, so there is no combinational
// loop. Assumes START < N; matrix bits are row-major (r*N+c).
module wfa_array #(
    parameter int N     = 4,
    parameter int START = 0
) (
    input  logic [N*N-1:0] req,
    output logic [N*N-1:0] gnt
);
    import wfa_pkg::*;

    // Free flags before step k (index k) and after the last step (index N).
    logic [N:0][N-1:0] row_free;
    logic [N:0][N-1:0] col_free;

    // Chain origin: at the start diagonal every row and column is free.
    assign row_free[0] = '1;
    assign col_free[0] = '1;

    for (genvar k = 0; k < N; k++) begin : g_step
        for (genvar r = 0; r < N; r++) begin : g_row
            localparam int COL = int'(col_at(START, k, r, N));
            wfa_tile u_tile (
                .req_i      (req[r*N+COL]),
                .row_free_i (row_free[k][r]),
                .col_free_i (col_free[k][COL]),
                .gnt_o      (gnt[r*N+COL]),
                .row_free_o (row_free[k+1][r]),
                .col_free_o (col_free[k+1][COL])
            );
        end
    end

endmodule

// File: rtl/wfa_select.sv
// Module wfa_select
// AND-OR selector that passes on the grant matrix of the copy whose start
// diagonal equals the priority pointer. Assumes sel < N.
module wfa_select #(
    parameter int N = 4,
    localparam int NN = N * N,
    localparam int PW = wfa_pkg::idx_w(N)
) (
    input  logic [N-1:0][NN-1:0] copies,
    input  logic [PW-1:0]        sel,
    output logic [NN-1:0]        gnt
);

    // Merge the one copy whose index matches the pointer.
    always_comb begin
        gnt = '0;
        for (int j = 0; j < N; j++) begin
            if (sel == PW'(j)) gnt = gnt | copies[j];
        end
    end

endmodule

// File: rtl/wfa_prio.sv
// Module wfa_prio
// Priority-diagonal pointer. Resets to 0, steps by one modulo N on each
// enabled cycle, holds otherwise. Synchronous active-low reset.
module wfa_prio #(
    parameter int N = 4,
    localparam int PW = wfa_pkg::idx_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic [PW-1:0] ptr_d;

    // Next pointer value with wrap from the last diagonal to the first.
    always_comb begin
        if (!adv)              ptr_d = ptr;
        else if (ptr == LAST)  ptr_d = '0;
        else                   ptr_d = ptr + PW'(1);
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_d;
    end

endmodule

// File: rtl/wfa_alloc.sv
// Module wfa_alloc
// N x N single-cycle wavefront allocator without combinational loops.
// One wavefront copy per start diagonal is built; the copy chosen by the
// rotating priority pointer drives the grants. Grants are combinational
// from req and the pointer; the pointer moves when alloc_en is high.
module wfa_alloc #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_en,
    input  logic [N*N-1:0] req,
    output logic [N*N-1:0] gnt
);
    import wfa_pkg::*;

    localparam int NN = N * N;
    localparam int PW = idx_w(N);

    logic [PW-1:0]        ptr_q;
    logic [N-1:0][NN-1:0] copy_gnt;

    // Replicated arrays, one per possible priority diagonal.
    for (genvar s = 0; s < N; s++) begin : g_copy
        wfa_array #(.N(N), .START(s)) u_copy (
            .req (req),
            .gnt (copy_gnt[s])
        );
    end

    wfa_select #(.N(N)) u_sel (
        .copies (copy_gnt),
        .sel    (ptr_q),
        .gnt    (gnt)
    );

    wfa_prio #(.N(N)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (alloc_en),
        .ptr   (ptr_q)
    );

endmodule

// File: rtl/wfa_alloc_chk.sv
// Module wfa_alloc_chk
// Property checker bound to wfa_alloc. Observes ports and the priority
// pointer; keeps one wait counter per request pair for the fairness bound.
module wfa_alloc_chk #(
    parameter int N = 4,
    localparam int NN = N * N,
    localparam int PW = wfa_pkg::idx_w(N),
    localparam int CW = wfa_pkg::idx_w(N) + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_en,
    input logic [NN-1:0] req,
    input logic [NN-1:0] gnt,
    input logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(N - 1);

    logic line_clash;
    logic not_maximal;
    logic [NN-1:0][CW-1:0] wait_q;

    // Row/column conflict and maximality flags of the current grants.
    always_comb begin
        logic [N-1:0] row_hit, col_hit;
        line_clash  = 1'b0;
        not_maximal = 1'b0;
        row_hit     = '0;
        col_hit     = '0;
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (gnt[r*N+c]) begin
                    if (row_hit[r] || col_hit[c]) line_clash = 1'b1;
                    row_hit[r] = 1'b1;
                    col_hit[c] = 1'b1;
                end
            end
        end
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                if (req[r*N+c] && !row_hit[r] && !col_hit[c]) not_maximal = 1'b1;
            end
        end
    end

    // Count enabled allocations that leave a held request ungranted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else begin
            for (int i = 0; i < NN; i++) begin
                if (!req[i] || gnt[i])  wait_q[i] <= '0;
                else if (alloc_en)      wait_q[i] <= wait_q[i] + CW'(1);
            end
        end
    end

    // R1
    gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R2
    one_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_clash);

    // R3
    maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !not_maximal);

    // R5
    ptr_reset_chk: assert property (@(posedge clk)
        !rst_n |=> ptr == '0);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && ptr != LAST) |=> ptr == $past(ptr) + PW'(1));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_en |=> $stable(ptr));

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && ptr == LAST) |=> ptr == '0);

    // R9
    for (genvar i = 0; i < NN; i++) begin : g_fair
        fair_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q[i] < CW'(N));
    end

endmodule

bind wfa_alloc wfa_alloc_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .req      (req),
    .gnt      (gnt),
    .ptr      (ptr_q)
);

// File: tb/sim_wfa_alloc.sv
`timescale 1ns/1ps
module sim_wfa_alloc;

    localparam int N  = 4;
    localparam int NN = N * N;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alloc_en;
    logic [NN-1:0] req;
    logic [NN-1:0] gnt;

    int checks = 0;
    int errors = 0;
    int mdl_ptr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wfa_alloc #(.N(N)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc_en),
        .req      (req),
        .gnt      (gnt)
    );

    // Table: {request, expected grant}; entry i runs at pointer i mod 4.
    localparam logic [31:0] VEC [8] = '{
        {16'hFFFF, 16'h2481},   // ptr 0, full matrix: diagonal 0
        {16'hFFFF, 16'h4812},   // ptr 1, full matrix: diagonal 1
        {16'h0000, 16'h0000},   // ptr 2, no requests (R8)
        {16'h000F, 16'h0008},   // ptr 3, one row asks for all
        {16'h4444, 16'h0400},   // ptr 0 after wrap (R7), one column
        {16'h0001, 16'h0001},   // ptr 1, lone request on diagonal 0
        {16'h0013, 16'h0001},   // ptr 2, maximal but not maximum
        {16'h8421, 16'h8421}    // ptr 3, identity fully granted
    };

    // Independent diagonal-walk model of the allocator.
    function automatic logic [NN-1:0] ref_alloc(logic [NN-1:0] rq, int start);
        logic [NN-1:0] g = '0;
        logic [N-1:0] rt = '0, ct = '0;
        for (int k = 0; k < N; k++) begin
            int d = (start + k) % N;
            for (int r = 0; r < N; r++) begin
                int c = (d - r + N) % N;
                if (rq[r*N+c] && !rt[r] && !ct[c]) begin
                    g[r*N+c] = 1'b1;
                    rt[r] = 1'b1;
                    ct[c] = 1'b1;
                end
            end
        end
        return g;
    endfunction

    function automatic bit lines_ok(logic [NN-1:0] g);
        for (int r = 0; r < N; r++) begin
            int nr = 0, nc = 0;
            for (int c = 0; c < N; c++) begin
                nr += int'(g[r*N+c]);
                nc += int'(g[c*N+r]);
            end
            if (nr > 1 || nc > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit is_maximal(logic [NN-1:0] rq, logic [NN-1:0] g);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                bit rb = 1'b0, cb = 1'b0;
                for (int j = 0; j < N; j++) begin
                    rb |= g[r*N+j];
                    cb |= g[j*N+c];
                end
                if (rq[r*N+c] && !rb && !cb) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [NN-1:0] act, logic [NN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (req %h ptr %0d)",
                     tag, act, exp, req, mdl_ptr);
        end
    endtask

    task automatic chk_b(string tag, bit ok);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual gnt %h expected property to hold (req %h)",
                     tag, gnt, req);
        end
    endtask

    // One clock edge; the model pointer follows alloc_en.
    task automatic tick();
        @(posedge clk);
        if (!rst_n)        mdl_ptr = 0;
        else if (alloc_en) mdl_ptr = (mdl_ptr + 1) % N;
        #1;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int waited;
        rst_n = 1'b0;
        alloc_en = 1'b0;
        req = '1;
        tick();
        tick();
        // R5: pointer at 0 during reset, full matrix gives diagonal 0.
        @(negedge clk);
        chk("R5 reset grants", gnt, 16'h2481);
        tick();
        rst_n = 1'b1;

        // R4 table walk with alloc_en high each cycle.
        for (int i = 0; i < 8; i++) begin
            req = VEC[i][31:16];
            alloc_en = 1'b1;
            @(negedge clk);
            if (i == 2)      chk("R8 empty request", gnt, VEC[i][15:0]);
            else if (i == 4) chk("R7 wrap to diagonal 0", gnt, VEC[i][15:0]);
            else             chk("R4 table", gnt, VEC[i][15:0]);
            chk("R4 model", gnt, ref_alloc(req, mdl_ptr));
            tick();
        end

        // R6: pointer holds while alloc_en is low.
        req = '1;
        alloc_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 hold", gnt, 16'h2481);
            tick();
        end
        alloc_en = 1'b1;
        tick();
        @(negedge clk);
        chk("R6 step after hold", gnt, 16'h4812);

        // R1..R4 on pseudo-random matrices with random enables.
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req = lfsr ^ {lfsr[7:0], lfsr[15:8]};
            alloc_en = lfsr[3] | lfsr[9];
            @(negedge clk);
            chk("R1 grant subset", gnt & ~req, '0);
            chk_b("R2 one per row and column", lines_ok(gnt));
            chk_b("R3 maximal", is_maximal(req, gnt));
            chk("R4 random model", gnt, ref_alloc(req, mdl_ptr));
            tick();
        end

        // R9: pair (0,0) held against a full matrix is served within N.
        req = '1;
        alloc_en = 1'b1;
        waited = 0;
        @(negedge clk);
        while (!gnt[0] && waited <= N) begin
            tick();
            waited++;
            @(negedge clk);
        end
        checks++;
        if (!(gnt[0] && waited < N)) begin
            errors++;
            $display("FAIL R9: actual wait %0d expected below %0d", waited, N);
        end
        tick();

        // R5: reset in mid-run returns the pointer to 0.
        tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset mid-run", gnt, 16'h2481);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule